// File: doc/BRIEF.md
# Pipelined Vectoring-CORDIC Magnitude Unit

This unit turns a stream of complex spectral bins into their magnitudes. Each bin has a signed real part and a signed imaginary part. The unit returns the rounded Euclidean length sqrt(re² + im²) as an unsigned word that is one bit wider than an input component. It contains no multipliers. Both components are first folded onto the positive axes. A chain of shift-and-add micro-rotations in vectoring mode then drives the vector toward the x axis, one stage per output bit. A final constant scaling, also built from shifts and adds, removes the accumulated rotation gain.

The pipeline accepts a new bin on every clock and has no back-pressure. A valid flag travels alongside the data and marks which output words carry results. A downstream consumer, such as a log-scaling stage or a peak detector, samples `mag_o` whenever `valid_o` is high.

Top module: `cordic_mag_pipe`

## Requirements
- R1: While `rst_ni` is low, and until the first valid sample has crossed the pipeline after reset is released, `valid_o` is 0 and `mag_o` is 0.
- R2: `valid_o` reproduces `valid_i` exactly 18 clock edges later. Data presented with `valid_i` low produces no output word.
- R3: Samples presented on consecutive clocks without gaps each produce one result, in order, on consecutive clocks.
- R4: For every valid sample, `mag_o` (17-bit unsigned) lies within 2 LSB of round(sqrt(re² + im²)), where `re_i` and `im_i` are 16-bit two's complement. The result never exceeds 46343.
- R5: Changing the sign of either component leaves `mag_o` bit-identical.
- R6: The most negative component value, -32768, is handled without wrap. (-32768, 0) gives about 32768 and (-32768, -32768) gives about 46341, both within the R4 tolerance.
- R7: A valid sample with both components equal to 0 yields exactly 0.
- R8: Whenever `valid_o` is low, `mag_o` is driven to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input bin present |
| re_i | input | 16 | Real component, two's complement |
| im_i | input | 16 | Imaginary component, two's complement |
| valid_o | output | 1 | Result present |
| mag_o | output | 17 | Rounded magnitude, unsigned |

## Verification
The hardest conditions to reach from the ports are the sign-fold corners. With -32768 on one or both inputs, the absolute value only fits if the widening is correct. Sign-mirrored copies of one vector must come out bit-identical even though they enter the pipeline on different clocks. The stimulus sends these corners directly: all four sign combinations of two fixed vectors, the extreme negative pairs, and the all-zero pair. It then runs a long gap-free random stream followed by a stream with periodic bubbles, so that every stage holds different data on every clock while invalid words carry random garbage on the inputs.

// File: rtl/cordic_mag_pkg.sv
package cordic_mag_pkg;
  // inverse of the vectoring gain, converged for 12 or more micro-rotations
  localparam real GAIN_INV = 0.6072529350088813;

  function automatic int gain_q(input int frac);
    return $rtoi(GAIN_INV * (2.0 ** frac) + 0.5);
  endfunction
endpackage

// File: rtl/cordic_mag_fold.sv
module cordic_mag_fold #(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  parameter int W     = DW + 3 + GUARD
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [DW-1:0]       re_i,
  input  logic [DW-1:0]       im_i,
  output logic                valid_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  localparam int PAD = W - DW - 1 - GUARD;

  logic signed [DW:0] re_ext, im_ext, re_abs, im_abs;

  // widen by one bit so that the most negative value has a positive twin
  always_comb begin
    re_ext = {re_i[DW-1], re_i};
    im_ext = {im_i[DW-1], im_i};
    re_abs = re_ext[DW] ? -re_ext : re_ext;
    im_abs = im_ext[DW] ? -im_ext : im_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      x_o     <= {{PAD{1'b0}}, re_abs, {GUARD{1'b0}}};
      y_o     <= {{PAD{1'b0}}, im_abs, {GUARD{1'b0}}};
    end
  end
endmodule

// File: rtl/cordic_mag_stage.sv
module cordic_mag_stage #(
  parameter int W  = 23,
  parameter int SH = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] y_i,
  output logic                valid_o,
  output logic signed [W-1:0] x_o,
  output logic signed [W-1:0] y_o
);
  logic signed [W-1:0] x_sh, y_sh, x_nx, y_nx;

  always_comb begin
    x_sh = x_i >>> SH;
    y_sh = y_i >>> SH;
    // rotate toward the x axis: direction set by the sign of y
    if (!y_i[W-1]) begin
      x_nx = x_i + y_sh;
      y_nx = y_i - x_sh;
    end else begin
      x_nx = x_i - y_sh;
      y_nx = y_i + x_sh;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      x_o     <= '0;
      y_o     <= '0;
    end else begin
      valid_o <= valid_i;
      x_o     <= x_nx;
      y_o     <= y_nx;
    end
  end
endmodule

// File: rtl/cordic_mag_scale.sv
module cordic_mag_scale #(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  parameter int W     = DW + 3 + GUARD,
  parameter int KFRAC = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic signed [W-1:0] x_i,
  output logic                valid_o,
  output logic [DW:0]         mag_o
);
  import cordic_mag_pkg::*;

  localparam int OW = DW + 1;
  localparam int PW = W - 1 + KFRAC;
  localparam int RS = GUARD + KFRAC;
  localparam logic [KFRAC-1:0] K_Q = KFRAC'(gain_q(KFRAC));
  localparam logic [PW-1:0] HALF = PW'(1) << (RS - 1);

  logic [W-2:0]  xu;
  logic [PW-1:0] acc, rnd;
  logic [OW-1:0] sat;

  always_comb begin
    xu  = x_i[W-1] ? '0 : x_i[W-2:0];
    acc = '0;
    // constant multiply by shift-and-add over the set bits of K_Q
    for (int b = 0; b < KFRAC; b++) begin
      if (K_Q[b]) acc = acc + (PW'(xu) << b);
    end
    rnd = (acc + HALF) >> RS;
    sat = (|rnd[PW-1:OW]) ? '1 : rnd[OW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mag_o   <= '0;
    end else begin
      valid_o <= valid_i;
      mag_o   <= valid_i ? sat : '0;
    end
  end
endmodule

// File: rtl/cordic_mag_pipe.sv
module cordic_mag_pipe #(
  parameter int DW    = 16,
  parameter int GUARD = 4,
  parameter int KFRAC = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] re_i,
  input  logic [DW-1:0] im_i,
  output logic          valid_o,
  output logic [DW:0]   mag_o
);
  localparam int N_STG = DW;
  localparam int W     = DW + 3 + GUARD;
  localparam int LAT   = N_STG + 2;

  logic                v_s [0:N_STG];
  logic signed [W-1:0] x_s [0:N_STG];
  logic signed [W-1:0] y_s [0:N_STG];

  cordic_mag_fold #(.DW(DW), .GUARD(GUARD), .W(W)) fold_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .re_i    (re_i),
    .im_i    (im_i),
    .valid_o (v_s[0]),
    .x_o     (x_s[0]),
    .y_o     (y_s[0])
  );

  for (genvar g = 0; g < N_STG; g++) begin : g_stage
    cordic_mag_stage #(.W(W), .SH(g)) stage_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .valid_i (v_s[g]),
      .x_i     (x_s[g]),
      .y_i     (y_s[g]),
      .valid_o (v_s[g+1]),
      .x_o     (x_s[g+1]),
      .y_o     (y_s[g+1])
    );
  end

  cordic_mag_scale #(.DW(DW), .GUARD(GUARD), .W(W), .KFRAC(KFRAC)) scale_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (v_s[N_STG]),
    .x_i     (x_s[N_STG]),
    .valid_o (valid_o),
    .mag_o   (mag_o)
  );
endmodule

// File: rtl/cordic_mag_chk.sv
module cordic_mag_chk #(
  parameter int DW  = 16,
  parameter int LAT = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic [DW-1:0] re_i,
  input logic [DW-1:0] im_i,
  input logic          valid_o,
  input logic [DW:0]   mag_o
);
  localparam longint MAG_MAX = ((64'd1 << (DW - 1)) * 14143) / 10000 + 1;

  logic [LAT-1:0] v_sh, z_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sh <= '0;
      z_sh <= '0;
    end else begin
      v_sh <= {v_sh[LAT-2:0], valid_i};
      z_sh <= {z_sh[LAT-2:0], valid_i && (re_i == '0) && (im_i == '0)};
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sh[LAT-1]); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> mag_o == '0); // R8

  AST_ZERO_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && z_sh[LAT-1]) |-> mag_o == '0); // R7

  AST_MAG_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> longint'(mag_o) <= MAG_MAX); // R4
endmodule

bind cordic_mag_pipe cordic_mag_chk #(.DW(DW), .LAT(LAT)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .re_i    (re_i),
  .im_i    (im_i),
  .valid_o (valid_o),
  .mag_o   (mag_o)
);

// File: tb/cordic_mag_pipe_tb_top.sv
module cordic_mag_pipe_tb_top;
  localparam int DW  = 16;
  localparam int LAT = 18;
  localparam int TOL = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [DW-1:0] re_i = '0;
  logic [DW-1:0] im_i = '0;
  logic          valid_o;
  logic [DW:0]   mag_o;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  bit    ev_q[$];
  int    em_q[$];
  string tag_q[$];
  int    grp_q[$];
  int    sym_ref[int];

  always #5 clk_i = ~clk_i;

  cordic_mag_pipe dut_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .re_i    (re_i),
    .im_i    (im_i),
    .valid_o (valid_o),
    .mag_o   (mag_o)
  );

  function automatic int ref_mag(input int re, input int im);
    real r;
    r = $sqrt(real'(re) * real'(re) + real'(im) * real'(im));
    return $rtoi(r + 0.5);
  endfunction

  task automatic fail(input string tag, input int act, input int exp);
    n_err++;
    $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
  endtask

  // called at a falling edge, before new inputs are driven
  task automatic check_out();
    bit ev; int em; string tag; int grp; int d;
    if (ev_q.size() < LAT) begin
      // R1: pipeline still empty after reset
      n_chk++;
      if (valid_o !== 1'b0 || mag_o !== '0) fail("R1", int'(mag_o) + (valid_o ? 100000 : 0), 0);
      return;
    end
    ev = ev_q.pop_front(); em = em_q.pop_front();
    tag = tag_q.pop_front(); grp = grp_q.pop_front();
    n_chk++;
    if (valid_o !== ev) fail("R2 valid", int'(valid_o), int'(ev));
    if (ev) begin
      d = int'(mag_o) - em;
      if (d < 0) d = -d;
      n_chk++;
      if (tag == "R7") begin
        if (d != 0) fail(tag, int'(mag_o), em);
      end else if (d > TOL) fail(tag, int'(mag_o), em);
      if (grp >= 0) begin
        if (sym_ref.exists(grp)) begin
          n_chk++; // R5 exact match across sign variants
          if (int'(mag_o) != sym_ref[grp]) fail("R5", int'(mag_o), sym_ref[grp]);
        end else sym_ref[grp] = int'(mag_o);
      end
    end else begin
      n_chk++; // R8
      if (mag_o !== '0) fail("R8", int'(mag_o), 0);
    end
  endtask

  task automatic drv(input int re, input int im, input bit v, input string tag, input int grp);
    @(negedge clk_i);
    check_out();
    valid_i = v;
    re_i    = re[DW-1:0];
    im_i    = im[DW-1:0];
    ev_q.push_back(v);
    em_q.push_back(v ? ref_mag(re, im) : 0);
    tag_q.push_back(tag);
    grp_q.push_back(grp);
  endtask

  function automatic int rnd16();
    return int'($urandom_range(65535)) - 32768;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(rnd16(), rnd16(), 1'b0, "R2", -1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    re_i = 16'h1234; im_i = 16'h8000; valid_i = 1'b1;
    repeat (3) @(negedge clk_i);
    n_chk++; // R1 during reset
    if (valid_o !== 1'b0 || mag_o !== '0) fail("R1", int'(mag_o), 0);
    valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    idle(LAT + 2); // R1 empty pipeline after reset

    // R7 zero vector, R6 extreme values, R4 axes and small vectors
    drv(0, 0, 1'b1, "R7", -1);
    drv(-32768, 0, 1'b1, "R6", -1);
    drv(0, -32768, 1'b1, "R6", -1);
    drv(-32768, -32768, 1'b1, "R6", -1);
    drv(32767, 32767, 1'b1, "R4", -1);
    drv(32767, 0, 1'b1, "R4", -1);
    drv(1, 0, 1'b1, "R4", -1);
    drv(0, -1, 1'b1, "R4", -1);
    drv(3, 4, 1'b1, "R4", -1);
    drv(0, 0, 1'b1, "R7", -1);

    // R5 sign mirrors of fixed vectors
    drv(1234, -567, 1'b1, "R5", 1);
    drv(-1234, -567, 1'b1, "R5", 1);
    drv(1234, 567, 1'b1, "R5", 1);
    drv(-1234, 567, 1'b1, "R5", 1);
    drv(-20000, 31000, 1'b1, "R5", 2);
    drv(20000, 31000, 1'b1, "R5", 2);
    drv(20000, -31000, 1'b1, "R5", 2);
    drv(-20000, -31000, 1'b1, "R5", 2);
    idle(5);

    // R3 gap-free random stream
    for (int i = 0; i < 300; i++) drv(rnd16(), rnd16(), 1'b1, "R3", -1);

    // R2 stream with bubbles carrying garbage data
    for (int i = 0; i < 120; i++) begin
      if (i % 3 == 1) drv(rnd16(), rnd16(), 1'b0, "R2", -1);
      else            drv(rnd16(), rnd16(), 1'b1, "R4", -1);
    end

    // R4 small magnitudes where rounding dominates
    for (int i = 0; i < 60; i++)
      drv(int'($urandom_range(64)) - 32, int'($urandom_range(64)) - 32, 1'b1, "R4", -1);

    idle(LAT + 4);
    done = 1'b1;
    finish_run();
  end
endmodule